// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Registers

This block holds the 64-byte type-0 configuration header of a single-function PCI agent. A bus-side controller hands it configuration accesses as a DWORD index, four active-high byte enables and a write strobe. The block returns the addressed DWORD without delay and updates only the writable bits of the enabled byte lanes. The identification fields are fixed by parameters. The command word, latency timer, both base address registers and the interrupt line can be written. The status word is cleared by writing ones to it and is set by event pulses from the rest of the core.

The block also supplies the rest of the core with the decoded command enables, the upper twelve bits of the memory and I/O base addresses, and the interrupt line. It holds a running copy of the latency timer. Each start of a master transaction reloads that copy, and it then counts down once per clock. Bus handshaking and parity generation are done elsewhere.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset, DWORD 0 reads 0x0001B325 (device ID 0x0001, vendor ID 0xB325), DWORD 1 reads 0x04000000, DWORD 2 reads 0xFF000001 (class 0xFF0000, revision 0x01), DWORD 3 reads 0x00000000, DWORD 4 reads 0x00000000, DWORD 5 reads 0x00000001 and DWORD 15 reads 0x001001FF (max latency 0x00, min grant 0x10, interrupt pin 0x01, interrupt line 0xFF).
- R2: Writes to DWORD 0, DWORD 2 and DWORD 11 (subsystem IDs, reset 0x00000000) change nothing that reads back.
- R3: In the command word (DWORD 1 bits 15:0), only bit 1 (memory enable), bit 2 (master enable), bit 6 (parity response) and bit 8 (system error enable) can be written. All other command bits read 0. The four enables are driven on output ports.
- R4: The status word (DWORD 1 bits 31:16) clears a bit when a 1 is written to it in an enabled lane and is unchanged by a 0. Status bits 10:9 always read 2'b10 (slow select timing). Without writes or events the status word holds its value.
- R5: Status bit 15 is set by an address or data parity event whatever parity response is set to. Bit 8 is set by a reported-parity event only while command bit 6 is 1. Bit 14 is set by a system-error event only while command bit 8 is 1. Bits 12 and 13 are set by target-abort and master-abort events.
- R6: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R7: The latency timer (DWORD 3 bits 15:8) has bits 7:3 writable and bits 2:0 reading 0. All other bytes of DWORD 3 read 0.
- R8: In BAR0 (DWORD 4) and BAR1 (DWORD 5), only bits 31:20 can be written. BAR0 bits 19:0 read 0. BAR1 bit 0 reads 1 and bits 19:1 read 0. Bits 31:20 of each are driven on output ports.
- R9: The interrupt line (DWORD 15 bits 7:0) can be written and is driven on a port. The other bytes of DWORD 15 are read-only.
- R10: Reads of DWORD indices 6 to 10 and 12 to 14, which include BAR2 to BAR5, return 0. Writes to them have no effect.
- R11: One clock after a master-start pulse, the latency count equals the latency timer. It then decreases by one each clock and stays at 0.
- R12: A write updates only the byte lanes whose enable is 1. Writable bits in other lanes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 4 | DWORD index into the header |
| acc_wr | input | 1 | Write strobe, one cycle per write |
| acc_be | input | 4 | Byte enables, active high, bit n for lane n |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr, combinational |
| ev_parity_err | input | 1 | Address or data parity error detected |
| ev_perr_rep | input | 1 | Data parity error reported |
| ev_serr | input | 1 | System error signaled |
| ev_tabort | input | 1 | Target abort event |
| ev_mabort | input | 1 | Master abort event |
| mst_start | input | 1 | Master transaction begins |
| mem_en | output | 1 | Command bit 1 |
| mstr_en | output | 1 | Command bit 2 |
| perr_en | output | 1 | Command bit 6 |
| serr_en | output | 1 | Command bit 8 |
| bar0_base | output | 12 | Memory base address bits 31:20 |
| bar1_base | output | 12 | I/O base address bits 31:20 |
| int_line | output | 8 | Interrupt line value |
| lat_count | output | 8 | Running latency count |

## Verification
The assertions check the status word on every cycle: it must hold when idle, a clear with no competing event must take effect, and the parity-detect and gated report bits must follow their events. They also check the latency count's reload and countdown steps and the hard-wired zero fields of the command word, the base address registers and the unimplemented offsets. Some behaviour needs particular sequences that only the bench's scenarios produce. These are the reset contents, partial byte-lane writes, read-only fields ignoring writes, the set-over-clear collision, and the enable gating that is seen only after the command word has been rewritten.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int DW_ADDR_W = 4;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;

  typedef logic [DW_ADDR_W-1:0] dw_idx_t;
  typedef logic [DATA_W-1:0]    word_t;

  // DWORD indices fixed by the header layout that host software decodes
  localparam dw_idx_t DW_ID      = 4'd0;
  localparam dw_idx_t DW_CMDSTAT = 4'd1;
  localparam dw_idx_t DW_CLASS   = 4'd2;
  localparam dw_idx_t DW_MISC    = 4'd3;
  localparam dw_idx_t DW_MEMBAR  = 4'd4;
  localparam dw_idx_t DW_IOBAR   = 4'd5;
  localparam dw_idx_t DW_SUBSYS  = 4'd11;
  localparam dw_idx_t DW_INTR    = 4'd15;

  // command bit positions
  localparam int CMD_MEM  = 1;
  localparam int CMD_MST  = 2;
  localparam int CMD_PERR = 6;
  localparam int CMD_SERR = 8;

  // status bit positions
  localparam int ST_DPAR_REP = 8;
  localparam int ST_TABORT   = 12;
  localparam int ST_MABORT   = 13;
  localparam int ST_SERR     = 14;
  localparam int ST_DET_PAR  = 15;

  localparam logic [15:0] STAT_W1C   = 16'hF100;
  localparam logic [15:0] STAT_FIXED = 16'h0400;

  // writable masks per field, in DWORD bit positions
  localparam word_t WM_CMD  = 32'h0000_0146;
  localparam word_t WM_LAT  = 32'h0000_F800;
  localparam word_t WM_BAR  = 32'hFFF0_0000;
  localparam word_t WM_INTL = 32'h0000_00FF;

  // expand byte enables into a bit mask
  function automatic word_t lane_mask(input logic [LANES-1:0] be);
    word_t m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // masked update of a field: only enabled, writable bits take new data
  function automatic word_t merge_write(input word_t old_q, input word_t wdata,
                                        input word_t lanes, input word_t wmask);
    word_t upd;
    upd = lanes & wmask;
    return (old_q & ~upd) | (wdata & upd);
  endfunction

  // write-one-to-clear with event set winning over a clear
  function automatic logic [15:0] stat_next(input logic [15:0] q, input logic [15:0] clr,
                                            input logic [15:0] set);
    return ((q & ~clr) | set) & STAT_W1C;
  endfunction

  // latency copy step
  function automatic logic [7:0] lat_step(input logic [7:0] cnt);
    return (cnt == 8'd0) ? 8'd0 : cnt - 8'd1;
  endfunction

endpackage

// File: rtl/cfg_field_reg.sv
module cfg_field_reg
  import cfg_hdr_pkg::*;
#(
  parameter dw_idx_t ADDR  = '0,
  parameter word_t   WMASK = '0,
  parameter word_t   RESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  dw_idx_t          addr,
  input  logic [LANES-1:0] be,
  input  word_t            wdata,
  output word_t            q
);

  logic hit;
  assign hit = wr && (addr == ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RESET & WMASK;
    else if (hit) q <= merge_write(q, wdata, lane_mask(be), WMASK);
  end

endmodule

// File: rtl/cfg_stat_reg.sv
module cfg_stat_reg
  import cfg_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] clr_mask,
  input  logic [15:0] set_mask,
  output logic [15:0] stat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 16'h0000;
    else        stat_q <= stat_next(stat_q, clr_mask, set_mask);
  end

endmodule

// File: rtl/cfg_lat_count.sv
module cfg_lat_count
  import cfg_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] load_val,
  output logic [7:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= 8'd0;
    else if (start) count <= load_val;
    else            count <= lat_step(count);
  end

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'hB325,
  parameter logic [15:0] DEVICE_ID   = 16'h0001,
  parameter logic [23:0] CLASS_CODE  = 24'hFF0000,
  parameter logic [7:0]  REVISION_ID = 8'h01,
  parameter logic [7:0]  HEADER_TYPE = 8'h00,
  parameter logic [15:0] SUBSYS_ID   = 16'h0000,
  parameter logic [15:0] SUBSYS_VID  = 16'h0000,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GNT     = 8'h10,
  parameter logic [7:0]  MAX_LAT     = 8'h00
) (
  input  dw_idx_t     addr,
  input  word_t       cmd_word,
  input  logic [15:0] stat_q,
  input  word_t       lat_word,
  input  word_t       bar0_word,
  input  word_t       bar1_word,
  input  word_t       intl_word,
  output word_t       rdata
);

  always_comb begin
    unique case (addr)
      DW_ID:      rdata = {DEVICE_ID, VENDOR_ID};
      DW_CMDSTAT: rdata = {stat_q | STAT_FIXED, 16'h0000} | cmd_word;
      DW_CLASS:   rdata = {CLASS_CODE, REVISION_ID};
      DW_MISC:    rdata = {8'h00, HEADER_TYPE, 16'h0000} | lat_word;
      DW_MEMBAR:  rdata = bar0_word;
      DW_IOBAR:   rdata = bar1_word | 32'h0000_0001;
      DW_SUBSYS:  rdata = {SUBSYS_ID, SUBSYS_VID};
      DW_INTR:    rdata = {MAX_LAT, MIN_GNT, INT_PIN, 8'h00} | intl_word;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'hB325,
  parameter logic [15:0] DEVICE_ID   = 16'h0001,
  parameter logic [23:0] CLASS_CODE  = 24'hFF0000,
  parameter logic [7:0]  REVISION_ID = 8'h01,
  parameter logic [7:0]  HEADER_TYPE = 8'h00,
  parameter logic [15:0] SUBSYS_ID   = 16'h0000,
  parameter logic [15:0] SUBSYS_VID  = 16'h0000,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GNT     = 8'h10,
  parameter logic [7:0]  MAX_LAT     = 8'h00,
  parameter logic [7:0]  INT_LINE_RST = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  acc_addr,
  input  logic        acc_wr,
  input  logic [3:0]  acc_be,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  input  logic        ev_parity_err,
  input  logic        ev_perr_rep,
  input  logic        ev_serr,
  input  logic        ev_tabort,
  input  logic        ev_mabort,
  input  logic        mst_start,
  output logic        mem_en,
  output logic        mstr_en,
  output logic        perr_en,
  output logic        serr_en,
  output logic [11:0] bar0_base,
  output logic [11:0] bar1_base,
  output logic [7:0]  int_line,
  output logic [7:0]  lat_count
);

  localparam int NFLD = 5;
  localparam dw_idx_t FLD_ADDR [NFLD] = '{DW_CMDSTAT, DW_MISC, DW_MEMBAR, DW_IOBAR, DW_INTR};
  localparam word_t   FLD_MASK [NFLD] = '{WM_CMD, WM_LAT, WM_BAR, WM_BAR, WM_INTL};
  localparam word_t   FLD_RST  [NFLD] = '{32'h0, 32'h0, 32'h0, 32'h0, {24'h0, INT_LINE_RST}};

  word_t fld_q [NFLD];

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    cfg_field_reg #(
      .ADDR (FLD_ADDR[g]),
      .WMASK(FLD_MASK[g]),
      .RESET(FLD_RST[g])
    ) u_fld (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (acc_wr),
      .addr (acc_addr),
      .be   (acc_be),
      .wdata(acc_wdata),
      .q    (fld_q[g])
    );
  end

  // named views of the fields, used by the checker
  word_t cmd_word, lat_word, bar0_word, bar1_word, intl_word;
  assign cmd_word  = fld_q[0];
  assign lat_word  = fld_q[1];
  assign bar0_word = fld_q[2];
  assign bar1_word = fld_q[3];
  assign intl_word = fld_q[4];

  // status clear and set events
  logic        stat_wr;
  logic [15:0] clr_mask, set_mask, stat_q;
  word_t       wr_lanes;

  assign wr_lanes = lane_mask(acc_be);
  assign stat_wr  = acc_wr && (acc_addr == DW_CMDSTAT);
  assign clr_mask = stat_wr ? (acc_wdata[31:16] & wr_lanes[31:16]) : 16'h0000;

  always_comb begin
    set_mask              = 16'h0000;
    set_mask[ST_DET_PAR]  = ev_parity_err;
    set_mask[ST_DPAR_REP] = ev_perr_rep && cmd_word[CMD_PERR];
    set_mask[ST_SERR]     = ev_serr && cmd_word[CMD_SERR];
    set_mask[ST_TABORT]   = ev_tabort;
    set_mask[ST_MABORT]   = ev_mabort;
  end

  cfg_stat_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_mask(clr_mask),
    .set_mask(set_mask),
    .stat_q  (stat_q)
  );

  cfg_lat_count u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (mst_start),
    .load_val(lat_word[15:8]),
    .count   (lat_count)
  );

  cfg_rd_mux #(
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .CLASS_CODE (CLASS_CODE),
    .REVISION_ID(REVISION_ID),
    .HEADER_TYPE(HEADER_TYPE),
    .SUBSYS_ID  (SUBSYS_ID),
    .SUBSYS_VID (SUBSYS_VID),
    .INT_PIN    (INT_PIN),
    .MIN_GNT    (MIN_GNT),
    .MAX_LAT    (MAX_LAT)
  ) u_mux (
    .addr     (acc_addr),
    .cmd_word (cmd_word),
    .stat_q   (stat_q),
    .lat_word (lat_word),
    .bar0_word(bar0_word),
    .bar1_word(bar1_word),
    .intl_word(intl_word),
    .rdata    (acc_rdata)
  );

  assign mem_en    = cmd_word[CMD_MEM];
  assign mstr_en   = cmd_word[CMD_MST];
  assign perr_en   = cmd_word[CMD_PERR];
  assign serr_en   = cmd_word[CMD_SERR];
  assign bar0_base = bar0_word[31:20];
  assign bar1_base = bar1_word[31:20];
  assign int_line  = intl_word[7:0];

endmodule

// File: rtl/cfg_hdr_regs_chk.sv
module cfg_hdr_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  acc_addr,
  input logic        acc_wr,
  input logic [3:0]  acc_be,
  input logic [31:0] acc_wdata,
  input logic [31:0] acc_rdata,
  input logic        ev_parity_err,
  input logic        ev_perr_rep,
  input logic        ev_serr,
  input logic        ev_tabort,
  input logic        ev_mabort,
  input logic        perr_en,
  input logic [15:0] stat_q,
  input logic [31:0] lat_word,
  input logic        mst_start,
  input logic [7:0]  lat_count
);

  logic any_ev;
  assign any_ev = ev_parity_err | ev_perr_rep | ev_serr | ev_tabort | ev_mabort;

  p_stat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_wr && acc_addr == 4'd1) && !any_ev) |=> $stable(stat_q));

  p_stat_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_addr == 4'd1 && acc_be[3] && acc_wdata[31] && !ev_parity_err) |=> !stat_q[15]);

  p_det_par_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_parity_err |=> stat_q[15]);

  p_rep_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[8]) |-> $past(perr_en && ev_perr_rep));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_parity_err && acc_wr && acc_addr == 4'd1 && acc_be[3] && acc_wdata[31]) |=> stat_q[15]);

  p_cmd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 4'd1) |-> ((acc_rdata[15:0] & ~16'h0146) == 16'h0000 && acc_rdata[26:25] == 2'b10));

  p_lat_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 4'd3) |-> (acc_rdata[10:8] == 3'b000 && acc_rdata[7:0] == 8'h00));

  p_bar_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 4'd4) |-> (acc_rdata[19:0] == 20'h0));

  p_iobar_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 4'd5) |-> (acc_rdata[19:0] == 20'h1));

  p_unimpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_addr >= 4'd6 && acc_addr <= 4'd10) || (acc_addr >= 4'd12 && acc_addr <= 4'd14))
      |-> (acc_rdata == 32'h0));

  p_lat_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mst_start |=> (lat_count == $past(lat_word[15:8])));

  p_lat_dec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_start && lat_count != 8'd0) |=> (lat_count == 8'($past(lat_count) - 8'd1)));

endmodule

bind cfg_hdr_regs cfg_hdr_regs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_addr     (acc_addr),
  .acc_wr       (acc_wr),
  .acc_be       (acc_be),
  .acc_wdata    (acc_wdata),
  .acc_rdata    (acc_rdata),
  .ev_parity_err(ev_parity_err),
  .ev_perr_rep  (ev_perr_rep),
  .ev_serr      (ev_serr),
  .ev_tabort    (ev_tabort),
  .ev_mabort    (ev_mabort),
  .perr_en      (perr_en),
  .stat_q       (stat_q),
  .lat_word     (lat_word),
  .mst_start    (mst_start),
  .lat_count    (lat_count)
);

// File: tb/cfg_hdr_regs_test.sv
module cfg_hdr_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        ev_parity_err = 1'b0, ev_perr_rep = 1'b0, ev_serr = 1'b0;
  logic        ev_tabort = 1'b0, ev_mabort = 1'b0, mst_start = 1'b0;
  logic        mem_en, mstr_en, perr_en, serr_en;
  logic [11:0] bar0_base, bar1_base;
  logic [7:0]  int_line, lat_count;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_hdr_regs uut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_be(acc_be),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .ev_parity_err(ev_parity_err),
    .ev_perr_rep(ev_perr_rep), .ev_serr(ev_serr), .ev_tabort(ev_tabort),
    .ev_mabort(ev_mabort), .mst_start(mst_start), .mem_en(mem_en), .mstr_en(mstr_en),
    .perr_en(perr_en), .serr_en(serr_en), .bar0_base(bar0_base), .bar1_base(bar1_base),
    .int_line(int_line), .lat_count(lat_count)
  );

  // {addr, be, wdata, expected readback after the write}
  localparam int NVEC = 12;
  localparam logic [71:0] VEC [NVEC] = '{
    {4'd1,  4'b0011, 32'hFFFF_FFFF, 32'h0400_0146},  // R3 only enable bits stick
    {4'd1,  4'b0001, 32'h0000_0000, 32'h0400_0100},  // R12 lane 1 keeps bit 8
    {4'd0,  4'b1111, 32'h0000_0000, 32'h0001_B325},  // R2
    {4'd4,  4'b1111, 32'hFFFF_FFFF, 32'hFFF0_0000},  // R8
    {4'd4,  4'b1000, 32'h1234_5678, 32'h12F0_0000},  // R12 top lane only
    {4'd5,  4'b1111, 32'hFFFF_FFFF, 32'hFFF0_0001},  // R8
    {4'd3,  4'b1111, 32'hFFFF_FFFF, 32'h0000_F800},  // R7
    {4'd15, 4'b1111, 32'h0000_00A5, 32'h0010_01A5},  // R9
    {4'd15, 4'b1110, 32'hFFFF_FF00, 32'h0010_01A5},  // R9 read-only bytes
    {4'd2,  4'b1111, 32'h0000_0000, 32'hFF00_0001},  // R2
    {4'd6,  4'b1111, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    {4'd11, 4'b1111, 32'hFFFF_FFFF, 32'h0000_0000}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    acc_addr = a; acc_be = be; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0; acc_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_addr = a;
    #1 d = acc_rdata;
  endtask

  task automatic pulse(input logic [4:0] ev);
    @(negedge clk);
    {ev_parity_err, ev_perr_rep, ev_serr, ev_tabort, ev_mabort} = ev;
    @(negedge clk);
    {ev_parity_err, ev_perr_rep, ev_serr, ev_tabort, ev_mabort} = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents
    rd(4'd0, d);  check("R1 dw0", d, 32'h0001_B325);
    rd(4'd1, d);  check("R1 dw1", d, 32'h0400_0000);
    rd(4'd2, d);  check("R1 dw2", d, 32'hFF00_0001);
    rd(4'd3, d);  check("R1 dw3", d, 32'h0000_0000);
    rd(4'd4, d);  check("R1 dw4", d, 32'h0000_0000);
    rd(4'd5, d);  check("R1 dw5", d, 32'h0000_0001);
    rd(4'd15, d); check("R1 dw15", d, 32'h0010_01FF);
    check("R1 int_line", {24'h0, int_line}, 32'h0000_00FF);
    check("R1 enables", {28'h0, mem_en, mstr_en, perr_en, serr_en}, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][71:68], VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][71:68], d);
      check($sformatf("R2/R3/R7/R8/R9/R10/R12 vector %0d", i), d, VEC[i][31:0]);
    end
    check("R3 enable ports", {28'h0, mem_en, mstr_en, perr_en, serr_en}, 32'h1);
    check("R8 bar0_base", {20'h0, bar0_base}, 32'h12F);
    check("R8 bar1_base", {20'h0, bar1_base}, 32'hFFF);
    check("R9 int_line", {24'h0, int_line}, 32'hA5);

    // R5 status events, parity response off
    pulse(5'b10000);
    rd(4'd1, d); check("R5 detect ignores enable", d, 32'h8400_0100);
    pulse(5'b01000);
    rd(4'd1, d); check("R5 report gated off", d, 32'h8400_0100);
    wr(4'd1, 4'b0001, 32'h0000_0040);
    pulse(5'b01000);
    rd(4'd1, d); check("R5 report enabled", d, 32'h8500_0140);
    pulse(5'b00111);
    rd(4'd1, d); check("R5 serr and aborts", d, 32'hF500_0140);

    // R4 write-one-to-clear
    wr(4'd1, 4'b1100, 32'h4000_0000);
    rd(4'd1, d); check("R4 clear bit 14 only", d, 32'hB500_0140);
    wr(4'd1, 4'b0011, 32'hFFFF_0000);
    rd(4'd1, d); check("R4 disabled status lanes", d, 32'hB500_0000);

    // R6 set beats clear
    @(negedge clk);
    acc_addr = 4'd1; acc_be = 4'b1100; acc_wdata = 32'h8000_0000; acc_wr = 1'b1;
    ev_parity_err = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0; acc_be = '0; ev_parity_err = 1'b0;
    rd(4'd1, d); check("R6 set over clear", d, 32'hB500_0000);

    wr(4'd1, 4'b1100, 32'hFFFF_0000);
    rd(4'd1, d); check("R4 clear all", d, 32'h0400_0000);
    pulse(5'b00100);
    rd(4'd1, d); check("R5 serr gated off", d, 32'h0400_0000);

    // R11 latency copy, timer reads 0xF8
    @(negedge clk); mst_start = 1'b1;
    @(negedge clk); mst_start = 1'b0;
    check("R11 load", {24'h0, lat_count}, 32'hF8);
    @(negedge clk);
    check("R11 first step", {24'h0, lat_count}, 32'hF7);
    repeat (8'hF7) @(negedge clk);
    check("R11 reaches zero", {24'h0, lat_count}, 32'h0);
    @(negedge clk);
    check("R11 holds zero", {24'h0, lat_count}, 32'h0);

    finish_run();
  end

endmodule